// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Core

This block gives a processor bus access to three 8-bit parallel ports, named A, B and C. The bus side has an 8-bit data path, an active-low chip select, active-low read and write strobes, and a two-bit register address. Each port pin has its own input, output value and output enable, so the pads sit outside the block. Port C is split into an upper nibble (lines 7..4) and a lower nibble (lines 3..0). In simple I/O mode each nibble's direction is set on its own. Ports A and B are each set as a whole.

Software sets the port directions by writing a mode word to the control address. It changes single port C lines by writing a set/reset command to the same address, and bit 7 of the written word tells the two apart. Output values are held in latches. Input values pass straight from the pins to the bus when read, with no latch. The data bus is split into an input, an output and an output enable, and the output enable stands for the tri-state control. Bus accesses are sampled on the rising clock edge. A write takes effect on every edge where chip select and the write strobe are both low.

Top module: `pario_core`

## Requirements
- R1: Address 00 selects port A, 01 selects port B, 10 selects port C and 11 selects the control register, for both reads and writes.
- R2: While chip select is high, the bus output enable stays low and no strobe changes any latch or direction.
- R3: While reset is high, every port output enable is low and every latch holds 0. This state also holds after the reset is released.
- R4: A control write with bit 7 = 1 is a mode word. Bit 4 sets port A to input, bit 1 sets port B to input, bit 3 sets the upper C nibble to input and bit 0 sets the lower C nibble to input (1 = input, 0 = output). Bits 6, 5 and 2 are ignored.
- R5: An output port drives its latched value on its pins with the enables high. A read of an output port returns that latched value.
- R6: A read of an input port returns the live pin value combinationally, with no latching.
- R7: A control write with bit 7 = 0 is a port C set/reset command. Bits 3..1 give the line index (000 = line 0 up to 111 = line 7), and bit 0 is the new value. All other C latch bits are unchanged and bits 6..4 are ignored. The C latch is updated even when that nibble is an input.
- R8: Every mode word clears the A, B and C output latches to 0.
- R9: The bus output enable is high only when chip select and the read strobe are both low and the address is not 11. A control-address read leaves the bus undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Reset, active high, asynchronous assert |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| dbus_i | input | 8 | Write data from the processor |
| dbus_o | output | 8 | Read data to the processor |
| dbus_oe | output | 1 | Bus drive enable (low = high impedance) |
| pa_i | input | 8 | Port A pin values |
| pa_o | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pin values |
| pb_o | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pin values |
| pc_o | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C output enables |

## Verification
The assertions assume that the bus strobes and address are synchronous to `clk` and stable around each rising edge. They also assume that a held write strobe means one write per edge, so a long strobe repeats an idempotent access. The bench drives every bus signal on the falling edge and holds each write strobe for exactly one rising edge. It never asserts read and write together, which keeps the stimulus inside these assumptions while the addresses, data words and pin values are random.

// File: rtl/pario_pkg.sv
package pario_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);

  localparam logic [1:0] ADR_A   = 2'b00;
  localparam logic [1:0] ADR_B   = 2'b01;
  localparam logic [1:0] ADR_C   = 2'b10;
  localparam logic [1:0] ADR_CTL = 2'b11;

  // Output enables per port group: 1 = drive pins
  typedef struct packed {
    logic a;
    logic b;
    logic cu;
    logic cl;
  } port_dir_t;
endpackage

// File: rtl/pario_bus_dec.sv
module pario_bus_dec
  import pario_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  output logic       wr_a,
  output logic       wr_b,
  output logic       wr_c,
  output logic       wr_ctl,
  output logic       rd_drive
);
  logic wr_act;

  always_comb begin
    wr_act   = !cs_n && !wr_n;
    wr_a     = wr_act && (addr == ADR_A);
    wr_b     = wr_act && (addr == ADR_B);
    wr_c     = wr_act && (addr == ADR_C);
    wr_ctl   = wr_act && (addr == ADR_CTL);
    rd_drive = !cs_n && !rd_n && (addr != ADR_CTL);
  end
endmodule

// File: rtl/pario_ctrl.sv
module pario_ctrl
  import pario_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] din,
  output port_dir_t         dir,
  output logic              clr_all,
  output logic              bit_en,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              bit_val
);
  port_dir_t dir_q, dir_d;
  logic      dir_en;
  logic      unused_rsvd;

  assign unused_rsvd = ^{din[6:5], din[2]};

  always_comb begin
    dir_en  = ctl_wr && din[7];
    clr_all = dir_en;
    bit_en  = ctl_wr && !din[7];
    bit_idx = din[3:1];
    bit_val = din[0];
    dir_d   = dir_q;
    if (dir_en) begin
      dir_d.a  = !din[4];
      dir_d.b  = !din[1];
      dir_d.cu = !din[3];
      dir_d.cl = !din[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  assign dir = dir_q;

  AST_MODE_A_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && din[7]) |=> (dir.a == !$past(din[4])) && (dir.cl == !$past(din[0]))) else $error("mode word"); // R4
  AST_BSR_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !din[7]) |=> $stable(dir)) else $error("bsr touched dir"); // R7
endmodule

// File: rtl/pario_latch.sv
module pario_latch #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          bit_en,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [W-1:0]  q
);
  logic [W-1:0] q_q, q_d;
  logic         q_en;

  always_comb begin
    q_en = clr || wr_en || bit_en;
    q_d  = q_q;
    if (clr)         q_d = '0;
    else if (wr_en)  q_d = wr_data;
    else if (bit_en) q_d[bit_idx] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (q_en) q_q <= q_d;
  end

  assign q = q_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0)) else $error("clear"); // R8
  AST_ONE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !clr && !wr_en) |=> ($countones(q ^ $past(q)) <= 1)) else $error("bsr"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_en && !bit_en) |=> $stable(q)) else $error("hold"); // R2
endmodule

// File: rtl/pario_core.sv
module pario_core
  import pario_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] dbus_i,
  output logic [DATA_W-1:0] dbus_o,
  output logic              dbus_oe,
  input  logic [DATA_W-1:0] pa_i,
  output logic [DATA_W-1:0] pa_o,
  output logic [DATA_W-1:0] pa_oe,
  input  logic [DATA_W-1:0] pb_i,
  output logic [DATA_W-1:0] pb_o,
  output logic [DATA_W-1:0] pb_oe,
  input  logic [DATA_W-1:0] pc_i,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] pc_oe
);
  logic [1:0] rst_sync;
  logic       rst_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or posedge rst) begin
    if (rst) rst_sync <= '0;
    else     rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  logic wr_a, wr_b, wr_c, wr_ctl, rd_drive;
  pario_bus_dec u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_ctl(wr_ctl), .rd_drive(rd_drive)
  );

  port_dir_t        dir;
  logic             clr_all, bit_en, bit_val;
  logic [IDX_W-1:0] bit_idx;
  pario_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(wr_ctl), .din(dbus_i), .dir(dir),
    .clr_all(clr_all), .bit_en(bit_en), .bit_idx(bit_idx), .bit_val(bit_val)
  );

  logic [DATA_W-1:0] lat_a, lat_b, lat_c;
  pario_latch #(.W(DATA_W)) u_lat_a (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .wr_en(wr_a), .wr_data(dbus_i),
    .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0), .q(lat_a)
  );
  pario_latch #(.W(DATA_W)) u_lat_b (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .wr_en(wr_b), .wr_data(dbus_i),
    .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0), .q(lat_b)
  );
  pario_latch #(.W(DATA_W)) u_lat_c (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .wr_en(wr_c), .wr_data(dbus_i),
    .bit_en(bit_en), .bit_idx(bit_idx), .bit_val(bit_val), .q(lat_c)
  );

  assign pa_o  = lat_a;
  assign pb_o  = lat_b;
  assign pc_o  = lat_c;
  assign pa_oe = {DATA_W{dir.a}};
  assign pb_oe = {DATA_W{dir.b}};
  assign pc_oe = {{NIB_W{dir.cu}}, {NIB_W{dir.cl}}};

  // per-line read source for port C: latch when driven, pin otherwise
  logic [DATA_W-1:0] rd_c;
  for (genvar g = 0; g < DATA_W; g++) begin : g_crd
    assign rd_c[g] = pc_oe[g] ? lat_c[g] : pc_i[g];
  end

  logic [DATA_W-1:0] rd_val;
  always_comb begin
    unique case (addr)
      ADR_A:   rd_val = dir.a ? lat_a : pa_i;
      ADR_B:   rd_val = dir.b ? lat_b : pb_i;
      ADR_C:   rd_val = rd_c;
      default: rd_val = '0;
    endcase
  end

  assign dbus_oe = rd_drive;
  assign dbus_o  = rd_drive ? rd_val : '0;

  AST_FLOAT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dbus_oe) else $error("bus driven while deselected"); // R2
  AST_CTL_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADR_CTL) |-> !dbus_oe) else $error("control read drove bus"); // R9
  AST_RESET_ALL_INPUT: assert property (@(posedge clk)
    !rst_n |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0)) else $error("reset dir"); // R3
endmodule

// File: tb/test_pario_core.sv
`timescale 1ns/1ps
module test_pario_core;
  logic       clk = 1'b0;
  logic       rst;
  logic       cs_n, rd_n, wr_n;
  logic [1:0] addr;
  logic [7:0] dbus_i, dbus_o, pa_i, pa_o, pa_oe, pb_i, pb_o, pb_oe, pc_i, pc_o, pc_oe;
  logic       dbus_oe;

  always #2.5 clk = ~clk;

  pario_core i_pario_core (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .dbus_i(dbus_i), .dbus_o(dbus_o), .dbus_oe(dbus_oe),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // reference model state
  bit       oa, ob, ocu, ocl;
  bit [7:0] la, lb, lc;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [7:0] exp_read(input bit [1:0] a);
    bit [7:0] c;
    for (int i = 0; i < 8; i++)
      c[i] = ((i >= 4) ? ocu : ocl) ? lc[i] : pc_i[i];
    case (a)
      2'd0:    return oa ? la : pa_i;
      2'd1:    return ob ? lb : pb_i;
      default: return c;
    endcase
  endfunction

  function automatic bit [7:0] exp_c_oe();
    return {{4{ocu}}, {4{ocl}}};
  endfunction

  task automatic model_write(input bit [1:0] a, input bit [7:0] d);
    case (a)
      2'd0: la = d;
      2'd1: lb = d;
      2'd2: lc = d;
      default: begin
        if (d[7]) begin
          oa = !d[4]; ob = !d[1]; ocu = !d[3]; ocl = !d[0];
          la = 0; lb = 0; lc = 0;
        end else lc[d[3:1]] = d[0];
      end
    endcase
  endtask

  task automatic check_pins(input string tag);
    chk(pa_oe == {8{oa}}, {tag, " R4 pa_oe"}, pa_oe, {8{oa}});
    chk(pb_oe == {8{ob}}, {tag, " R4 pb_oe"}, pb_oe, {8{ob}});
    chk(pc_oe == exp_c_oe(), {tag, " R4 pc_oe"}, pc_oe, exp_c_oe());
    chk(pa_o == la, {tag, " R5 pa_o"}, pa_o, la);
    chk(pb_o == lb, {tag, " R5 pb_o"}, pb_o, lb);
    chk(pc_o == lc, {tag, " R7 pc_o"}, pc_o, lc);
  endtask

  task automatic bus_write(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk);
    cs_n = 0; wr_n = 0; addr = a; dbus_i = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
    model_write(a, d);
  endtask

  task automatic bus_read(input bit [1:0] a, input string req);
    bit [7:0] e;
    @(negedge clk);
    cs_n = 0; rd_n = 0; addr = a;
    #0.5;
    if (a == 2'd3) chk(dbus_oe == 1'b0, {req, " R9 ctl read float"}, dbus_oe, 0);
    else begin
      e = exp_read(a);
      chk(dbus_oe == 1'b1, {req, " R1 drive"}, dbus_oe, 1);
      chk(dbus_o == e, {req, " R1 read data"}, dbus_o, e);
    end
    @(negedge clk);
    cs_n = 1; rd_n = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; cs_n = 1; rd_n = 1; wr_n = 1; addr = 0; dbus_i = 0;
    pa_i = 8'hC3; pb_i = 8'h3C; pc_i = 8'h96;
    oa = 0; ob = 0; ocu = 0; ocl = 0; la = 0; lb = 0; lc = 0;
    repeat (3) @(negedge clk);
    // R3: reset state while asserted
    chk(pa_oe == 0 && pb_oe == 0 && pc_oe == 0, "R3 oe in reset", {pa_oe, pb_oe, pc_oe}, 0);
    chk(pa_o == 0 && pb_o == 0 && pc_o == 0, "R3 latches in reset", {pa_o, pb_o, pc_o}, 0);
    rst = 0;
    repeat (3) @(negedge clk);
    check_pins("R3 after release");
    // R6: input ports read pins
    bus_read(2'd0, "R6 A in"); bus_read(2'd1, "R6 B in"); bus_read(2'd2, "R6 C in");
    // R6 unlatched: pin change visible during the same read
    @(negedge clk); cs_n = 0; rd_n = 0; addr = 2'd0; #0.5;
    pa_i = 8'h11; #0.5;
    chk(dbus_o == 8'h11, "R6 live pin", dbus_o, 8'h11);
    @(negedge clk); cs_n = 1; rd_n = 1;
    // R4: all outputs, R5 drive
    bus_write(2'd3, 8'h80); check_pins("R4 all out");
    bus_write(2'd0, 8'h5A); bus_write(2'd1, 8'hA5); bus_write(2'd2, 8'hF0);
    check_pins("R5 written");
    bus_read(2'd0, "R5 A out"); bus_read(2'd2, "R5 C out");
    // R2: deselected write and read
    @(negedge clk); cs_n = 1; wr_n = 0; addr = 2'd0; dbus_i = 8'h33;
    @(negedge clk); wr_n = 1;
    chk(pa_o == 8'h5A, "R2 deselected write ignored", pa_o, 8'h5A);
    @(negedge clk); cs_n = 1; rd_n = 0; #0.5;
    chk(dbus_oe == 0, "R2 deselected read float", dbus_oe, 0);
    rd_n = 1;
    // R9: control read
    bus_read(2'd3, "R9");
    // R7: set/reset, including ignored bits 6..4
    bus_write(2'd3, 8'h0F); check_pins("R7 set line 7");
    bus_write(2'd3, 8'h70); check_pins("R7 clear line 0, bits6..4 set");
    chk(pc_o == 8'hF0, "R7 expected pattern", pc_o, 8'hF0);
    // R8 and R4 mixed nibbles: upper C in, lower C out, A in, B out, reserved bits set
    bus_write(2'd3, 8'hFE & 8'b1111_1100 | 8'h08 | 8'h10 | 8'h64);
    check_pins("R8 clear on mode");
    chk(pc_o == 0, "R8 C cleared", pc_o, 0);
    bus_read(2'd2, "R4 mixed C");
    // R7 on input nibble still updates latch
    bus_write(2'd3, 8'h0B); check_pins("R7 input nibble latch");
    // random phase
    for (int n = 0; n < 600; n++) begin
      int op;
      bit [7:0] d;
      pa_i = $urandom; pb_i = $urandom; pc_i = $urandom;
      op = $urandom % 3;
      d = $urandom;
      if (op == 0) begin
        bus_write(2'($urandom % 4), d);
        check_pins("R1 random write");
      end else bus_read(2'($urandom % 4), "R1 random read");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule